// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block gives a bus master a small register window onto an embedded controller. Each direction has an eight-entry byte FIFO. The host writes the data register to queue a byte toward the controller, and the controller drains that queue through a valid/ready port. Bytes arriving from the controller land in a second FIFO. The host removes them one at a time by reading the data register. The byte always travels in bits 15:8 of the 32-bit data word.

Software watches four FIFO conditions through a status register:
- outbound queue empty
- outbound queue has room
- inbound queue holds data
- inbound queue overflowed

Each condition has an edge-triggered request flag and an enable mask. The interrupt output is the OR of the enabled requests. Request flags and the overflow flag are cleared by writing ones, so software can clear everything it just saw by writing the status value straight back.

Top module: `mbox_fifo_regs`

## Requirements
- R1: Word offset 0 is the interrupt register, offset 1 the data register and offset 2 the status register. Offsets 3 to 7 read as zero, and writes to them change nothing.
- R2: Status read value, bit 0 upward:
  - bit 0: outbound FIFO empty
  - bit 1: outbound FIFO not full
  - bit 2: inbound FIFO not empty
  - bit 3: inbound overflow flag
  - bits 31:4: zero
- R3: A data-register write pushes bits 15:8 of the write word into the outbound FIFO. `tx_valid` is high while the FIFO holds a byte, and `tx_data` shows the oldest byte. A byte leaves on a cycle with `tx_valid` and `tx_ready` both high, so bytes come out in write order.
- R4: A data-register read with the inbound FIFO non-empty returns the oldest byte in bits 15:8, with all other bits zero, and removes that byte.
- R5: A data-register read with the inbound FIFO empty returns zero and leaves the FIFO unchanged.
- R6: Both FIFOs hold 8 bytes. A data-register write while the outbound FIFO is full is dropped.
- R7: Overflow detection on the inbound side:
  - An `rx_valid` cycle while the inbound FIFO is full drops the byte and sets the overflow flag.
  - The flag stays set until a status-register write with bit 3 set.
  - If a new overflow and that clear fall in the same cycle, the overflow wins.
- R8: Request flags are interrupt-register bits 0 to 3, in the same order as status bits 0 to 3.
  - A flag sets in the cycle after its condition goes from false to true.
  - It holds until a 1 is written to that bit position in either the interrupt register or the status register.
  - If a set and a clear fall in the same cycle, the set wins.
- R9: Interrupt-register bits 7:4 are read/write enable masks for requests 0 to 3. `irq` is high exactly when some request bit and its mask bit are both set.
- R10: Writing the value just read from the status register back to the status register clears every request and the overflow flag that value reported, provided no new rising edge arrives in that cycle.
- R11: After reset:
  - both FIFOs are empty
  - masks, requests and the overflow flag are zero
  - `irq` is low
  - the status register reads 0x3
  - no request is raised by the reset state itself

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Outbound byte available |
| tx_ready | input | 1 | Controller takes the outbound byte |
| tx_data | output | 8 | Oldest outbound byte |
| rx_valid | input | 1 | Controller pushes an inbound byte |
| rx_data | input | 8 | Inbound byte |
| irq | output | 1 | Masked interrupt request |

## Verification
Random traffic mixes host writes and reads with a controller that stalls and pushes at random, so both FIFOs pass through empty, partly full and full. This tells ordering faults apart from pointer-wrap faults. Directed runs cover three cases:
- Writing while the outbound FIFO is held full with the controller stalled shows whether full writes are really dropped.
- Pushing nine inbound bytes shows the drop on a full FIFO and the sticky overflow flag.
- Reading the data register when the inbound FIFO is empty shows that such a read has no side effect.

Random mask and clear writes, together with a status read followed by a write-back of that value, separate edge-set requests from level-following ones and test the one-write clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // condition / request / status bit positions (shared by status and interrupt registers)
   localparam int COND_TXE  = 0;
   localparam int COND_TXNF = 1;
   localparam int COND_RXNE = 2;
   localparam int COND_RXOV = 3;
   localparam int N_COND    = 4;

   // register word offsets
   typedef enum logic [2:0] {
      REG_IRQ  = 3'd0,
      REG_DATA = 3'd1,
      REG_STAT = 3'd2
   } mbox_reg_e;

   // condition levels right after reset (outbound empty and not full)
   localparam logic [N_COND-1:0] COND_AT_RESET = 4'b0011;
endpackage

// File: rtl/mbox_byte_fifo.sv
module mbox_byte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbox_byte_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mbox_byte_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;
   logic [AW-1:0]    wr_next, rd_next;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   // pointer advance: natural wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_nat
      assign wr_next = wr_ptr + 1'b1;
      assign rd_next = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_next = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_next = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_next;
         if (do_pop)  rd_ptr <= rd_next;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl #(
   parameter int              N        = 4,
   parameter logic [N-1:0]    COND_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] clr,
   input  logic         mask_we,
   input  logic [N-1:0] mask_d,
   output logic [N-1:0] req,
   output logic [N-1:0] mask,
   output logic         irq
);
   if (N < 1) begin : g_bad_n
      $error("mbox_irq_ctrl: N must be positive");
   end

   logic [N-1:0] cond_q;

   // one flag per condition; set on rising edge beats a same-cycle clear
   for (genvar i = 0; i < N; i++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req[i]    <= 1'b0;
            cond_q[i] <= COND_RST[i];
         end else begin
            cond_q[i] <= cond[i];
            if (cond[i] & ~cond_q[i]) req[i] <= 1'b1;
            else if (clr[i])          req[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_d;
   end

   assign irq = |(req & mask);
endmodule

// File: rtl/mbox_fifo_regs.sv
module mbox_fifo_regs
   import mbox_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int BYTE_LSB = 8,
   parameter int ADDR_W   = 3,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data
   ,output logic             irq
);
   localparam int                MASK_LSB = N_COND;
   localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(REG_IRQ);
   localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(REG_STAT);

   if (BYTE_LSB + BYTE_W > DATA_W) begin : g_bad_lane
      $error("mbox_fifo_regs: byte lane exceeds data width");
   end
   if (2 * N_COND > DATA_W) begin : g_bad_irq_w
      $error("mbox_fifo_regs: interrupt register does not fit");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("mbox_fifo_regs: ADDR_W too small for three registers");
   end

   logic              wr, rd, hit_irq, hit_data, hit_stat;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [BYTE_W-1:0] rx_head;
   logic              ovf_q;
   logic [N_COND-1:0] cond, clr, req, mask;
   logic              unused_wdata;

   assign wr       = bus_sel & bus_we;
   assign rd       = bus_sel & ~bus_we;
   assign hit_irq  = (bus_addr == A_IRQ);
   assign hit_data = (bus_addr == A_DATA);
   assign hit_stat = (bus_addr == A_STAT);

   mbox_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr & hit_data),
      .push_data (bus_wdata[BYTE_LSB +: BYTE_W]),
      .pop       (tx_ready),
      .head      (tx_data),
      .empty     (tx_empty),
      .full      (tx_full)
   );
   assign tx_valid = ~tx_empty;

   mbox_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_valid),
      .push_data (rx_data),
      .pop       (rd & hit_data),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   // sticky overflow; a new overflow beats a same-cycle acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ovf_q <= 1'b0;
      else if (rx_valid & rx_full)                 ovf_q <= 1'b1;
      else if (wr & hit_stat & bus_wdata[COND_RXOV]) ovf_q <= 1'b0;
   end

   always_comb begin
      cond            = '0;
      cond[COND_TXE]  = tx_empty;
      cond[COND_TXNF] = ~tx_full;
      cond[COND_RXNE] = ~rx_empty;
      cond[COND_RXOV] = ovf_q;
   end

   assign clr = (wr & (hit_irq | hit_stat)) ? bus_wdata[N_COND-1:0] : '0;

   mbox_irq_ctrl #(.N(N_COND), .COND_RST(COND_AT_RESET)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (cond),
      .clr     (clr),
      .mask_we (wr & hit_irq),
      .mask_d  (bus_wdata[MASK_LSB +: N_COND]),
      .req     (req),
      .mask    (mask),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (hit_irq) begin
            bus_rdata[N_COND-1:0]          = req;
            bus_rdata[MASK_LSB +: N_COND]  = mask;
         end else if (hit_data) begin
            if (!rx_empty) bus_rdata[BYTE_LSB +: BYTE_W] = rx_head;
         end else if (hit_stat) begin
            bus_rdata[N_COND-1:0] = cond;
         end
      end
   end

   assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/mbox_fifo_regs_chk.sv
module mbox_fifo_regs_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [BYTE_W-1:0] tx_data,
   input logic              rx_valid,
   input logic              rx_full,
   input logic              rx_empty,
   input logic              ovf_q,
   input logic [3:0]        req,
   input logic [3:0]        mask,
   input logic              irq
);
   logic stat_wr_b3, req_clr_wr, data_rd;
   assign stat_wr_b3 = bus_sel & bus_we & (bus_addr == ADDR_W'(2)) & bus_wdata[3];
   assign req_clr_wr = bus_sel & bus_we & ((bus_addr == ADDR_W'(0)) | (bus_addr == ADDR_W'(2)));
   assign data_rd    = bus_sel & ~bus_we & (bus_addr == ADDR_W'(1));

   // R3: a stalled outbound byte stays put
   a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R5: empty inbound read returns zero
   a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && rx_empty) |-> (bus_rdata == '0));

   // R7: push into a full inbound FIFO raises overflow
   a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full) |=> ovf_q);

   // R7: overflow is sticky until acknowledged
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !stat_wr_b3) |=> ovf_q);

   // R8: without a clearing write no request bit falls
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_clr_wr |=> ((req & $past(req)) == $past(req)));

   // R9: nothing enabled means no interrupt
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 4'b0) |-> !irq);

   // R9: interrupt only with some request pending
   a_r9_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (req != 4'b0));
endmodule

bind mbox_fifo_regs mbox_fifo_regs_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .rx_valid  (rx_valid),
   .rx_full   (rx_full),
   .rx_empty  (rx_empty),
   .ovf_q     (ovf_q),
   .req       (req),
   .mask      (mask),
   .irq       (irq)
);

// File: tb/sim_mbox_fifo_regs.sv
module sim_mbox_fifo_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_valid, tx_ready = 1'b0;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        irq;

   always #5 clk = ~clk;

   mbox_fifo_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   logic [7:0]  txq[$];
   logic [7:0]  rxq[$];
   bit          m_ovf;
   logic [3:0]  m_req, m_mask, m_prev;
   logic [31:0] last_rd;

   function automatic logic [3:0] m_cond();
      return {m_ovf, rxq.size() != 0, txq.size() < 8, txq.size() == 0};
   endfunction

   function automatic logic [31:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return {24'b0, m_mask, m_req};
         3'd1: return (rxq.size() != 0) ? {16'b0, rxq[0], 8'b0} : 32'b0;
         3'd2: return {28'b0, m_cond()};
         default: return 32'b0;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic cyc(bit s, bit w, logic [2:0] a, logic [31:0] d,
                      bit tr, bit rv, logic [7:0] rd8, string tg = "");
      logic [3:0] c, clr;
      bit tfull, rfull, rnon;
      string t;
      @(negedge clk);
      bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
      tx_ready = tr; rx_valid = rv; rx_data = rd8;
      #1;
      chk("R3 tx_valid", {31'b0, tx_valid}, {31'b0, txq.size() != 0});
      if (txq.size() != 0) chk("R3 tx_data order", {24'b0, tx_data}, {24'b0, txq[0]});
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_req & m_mask)});
      if (s && !w) begin
         last_rd = bus_rdata;
         if (tg != "") t = tg;
         else case (a)
            3'd0: t = "R8 irq reg";
            3'd1: t = (rxq.size() != 0) ? "R4 data read" : "R5 empty read";
            3'd2: t = "R2 status";
            default: t = "R1 reserved";
         endcase
         chk(t, bus_rdata, m_read(a));
      end
      // reference update at the edge
      c = m_cond();
      clr = (s && w && (a == 3'd0 || a == 3'd2)) ? d[3:0] : 4'b0;
      m_req = (m_req & ~clr) | (c & ~m_prev);
      m_prev = c;
      if (s && w && a == 3'd0) m_mask = d[7:4];
      tfull = (txq.size() == 8);
      rfull = (rxq.size() == 8);
      rnon  = (rxq.size() != 0);
      if (rv && rfull) m_ovf = 1;
      else if (s && w && a == 3'd2 && d[3]) m_ovf = 0;
      if (tr && txq.size() != 0) void'(txq.pop_front());
      if (s && w && a == 3'd1 && !tfull) txq.push_back(d[15:8]);
      if (s && !w && a == 3'd1 && rnon) void'(rxq.pop_front());
      if (rv && !rfull) rxq.push_back(rd8);
      @(posedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 32'h0, 0, 0, 8'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(10 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int unsigned r;
      r = $urandom(32'd20240611);
      m_ovf = 0; m_req = 0; m_mask = 0; m_prev = 4'b0011;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R11: reset state
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R11 status after reset");
      cyc(1, 0, 3'd0, 0, 0, 0, 0, "R11 irq reg after reset");
      chk("R11 irq low", {31'b0, irq}, 32'b0);

      // R1: reserved offsets
      for (int k = 3; k < 8; k++) cyc(1, 1, 3'(k), 32'hFFFF_FFFF, 0, 0, 0);
      for (int k = 3; k < 8; k++) cyc(1, 0, 3'(k), 0, 0, 0, 0, "R1 reserved zero");
      cyc(1, 0, 3'd0, 0, 0, 0, 0, "R1 reserved write no effect");

      // R6: overfill outbound with the controller stalled
      cyc(1, 1, 3'd0, 32'h0000_00F0, 0, 0, 0);          // enable all masks (R9)
      for (int k = 0; k < 10; k++) cyc(1, 1, 3'd1, {16'b0, 8'(8'h40 + k), 8'hAA}, 0, 0, 0);
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R6 outbound full status");
      for (int k = 0; k < 9; k++) cyc(0, 0, 3'd0, 0, 1, 0, 0);   // drain; R3 order checked per cycle
      cyc(1, 0, 3'd0, 0, 0, 0, 0, "R8 requests after drain");

      // R7: overfill inbound
      for (int k = 0; k < 9; k++) cyc(0, 0, 3'd0, 0, 0, 1, 8'(8'h90 + k));
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R7 overflow set");
      idle(3);
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R7 overflow sticky");
      for (int k = 0; k < 9; k++) cyc(1, 0, 3'd1, 0, 0, 0, 0);   // R4 pops, then R5 empty read
      cyc(1, 0, 3'd1, 0, 0, 0, 0, "R5 empty read zero");
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R5 empty read left FIFO unchanged");

      // R10: read status and write it back
      idle(2);
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R10 status before write-back");
      cyc(1, 1, 3'd2, last_rd, 0, 0, 0);
      cyc(1, 0, 3'd0, 0, 0, 0, 0, "R10 requests after write-back");
      cyc(1, 0, 3'd2, 0, 0, 0, 0, "R10 overflow after write-back");

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         int unsigned op;
         logic [31:0] d;
         bit tr, rv;
         op = $urandom % 10;
         d  = $urandom;
         tr = ($urandom % 3) != 0;
         rv = ($urandom % 5) < 2;
         case (op)
            0, 1, 2: cyc(1, 1, 3'd1, d, tr, rv, 8'($urandom));
            3, 4:    cyc(1, 0, 3'd1, 0, tr, rv, 8'($urandom));
            5:       cyc(1, 0, 3'd2, 0, tr, rv, 8'($urandom));
            6:       cyc(1, 1, 3'd2, d, tr, rv, 8'($urandom));
            7:       cyc(1, 1, 3'd0, d, tr, rv, 8'($urandom));
            8:       cyc(1, 0, 3'd0, 0, tr, rv, 8'($urandom));
            default: cyc(1, ($urandom % 2) == 1, 3'(3 + $urandom % 5), d, tr, rv, 8'($urandom));
         endcase
      end
      idle(2);
      finish_run();
   end
endmodule